// File: doc/BRIEF.md
# Execute Unit with Condition Flags

This block is the arithmetic stage of a small sequential processor. Each cycle it combines two operands under a 4-bit function code (add, subtract, bitwise AND, bitwise XOR) and presents the result with no clock delay. Alongside the arithmetic it keeps a three-bit flag register that records whether a result was zero, negative, or overflowed in signed terms. That register changes only at a rising clock edge on which the load enable is high.

A second 4-bit code selects a branch or conditional-move predicate. The predicate is tested against the stored flags, never against the flags the current operation is producing. An instruction that sets flags therefore influences only the predicates of later cycles. The surrounding processor drives the function codes and operands from its decoded instruction. It uses the one-bit predicate output to choose the next program counter or to decide whether a register write takes place.

Top module: `exec_unit`

## Requirements
- R1: Function code 0 yields `result = opnd_b + opnd_a` modulo 2^DW, combinationally in the same cycle.
- R2: Function code 1 yields `result = opnd_b - opnd_a` (second operand minus first), modulo 2^DW.
- R3: Function code 2 yields bitwise AND and code 3 yields bitwise XOR of the operands; every other function code (4 to 15) yields a zero result.
- R4: The flag value produced for an operation is {zero, negative, overflow} with zero in bit 2, negative in bit 1 and overflow in bit 0. Zero is set when the result is all zeros. Negative copies the result's top bit. Overflow marks signed overflow of add or subtract and is 0 for every other code.
- R5: `flags_q` takes the produced flag value at a rising edge where `set_flags` is 1 and `rst` is 0, and keeps its value at every edge where `set_flags` is 0.
- R6: A rising edge with `rst` high clears `flags_q` to 3'b000, whatever `set_flags` is.
- R7: `cond_true` evaluates `cond_fn` against `flags_q` (Z=bit2, N=bit1, V=bit0). Code 0 is always true, 1 is (N^V)|Z, 2 is N^V, 3 is Z, 4 is !Z, 5 is !(N^V), 6 is !(N^V)&!Z, and codes 7 to 15 are false.
- R8: Flags produced in a cycle reach `cond_true` only from the next cycle on; the predicate in the producing cycle still uses the earlier stored flags.
- R9: Adding 0x100 and 0x200 with flag load gives 0x300 and stores 3'b000, so a following equal test (code 3) is false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| fn_alu | input | 4 | Arithmetic/logic function select |
| opnd_a | input | DW | First operand |
| opnd_b | input | DW | Second operand (minuend for subtract) |
| set_flags | input | 1 | Load enable for the flag register |
| cond_fn | input | 4 | Predicate select evaluated against stored flags |
| result | output | DW | Combinational operation result |
| flags_q | output | 3 | Stored flags {zero, negative, overflow} |
| cond_true | output | 1 | Predicate outcome on stored flags |

## Verification
The bench builds the block with the default DW of 32. At that width, operands such as 0x7FFFFFFF and 0x80000000 reach the signed boundary, so both overflow directions for add and subtract can be driven with exact values. With 32 bits, wraparound to zero and the sign bit in position 31 can also be tested. A scoreboard model predicts the result, the stored flags and each predicate code cycle by cycle. Keeping the predicate on stored flags lets the one-cycle lag of R8 be observed directly.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_ANY = 4'd0,
        CC_LE  = 4'd1,
        CC_LT  = 4'd2,
        CC_EQ  = 4'd3,
        CC_NE  = 4'd4,
        CC_GE  = 4'd5,
        CC_GT  = 4'd6
    } cond_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    function automatic logic cond_eval(input logic [3:0] code, input flags_t f);
        logic lt;
        lt = f.neg ^ f.ovf;
        case (code)
            CC_ANY:  return 1'b1;
            CC_LE:   return lt | f.zero;
            CC_LT:   return lt;
            CC_EQ:   return f.zero;
            CC_NE:   return ~f.zero;
            CC_GE:   return ~lt;
            CC_GT:   return ~lt & ~f.zero;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output flags_t        nf
);
    localparam int MSB = DW - 1;

    logic ovf;

    always_comb begin
        ovf = 1'b0;
        case (fn)
            OP_ADD: begin
                y   = b + a;
                ovf = (a[MSB] == b[MSB]) && (y[MSB] != b[MSB]);
            end
            OP_SUB: begin
                y   = b - a;
                ovf = (a[MSB] != b[MSB]) && (y[MSB] != b[MSB]);
            end
            OP_AND:  y = b & a;
            OP_XOR:  y = b ^ a;
            default: y = '0;
        endcase
        nf.zero = (y == '0);
        nf.neg  = y[MSB];
        nf.ovf  = ovf;
    end

endmodule

// File: rtl/exec_ccreg.sv
module exec_ccreg
    import exec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/exec_cond.sv
module exec_cond
    import exec_pkg::*;
(
    input  logic [3:0] code,
    input  flags_t     f,
    output logic       taken
);
    always_comb begin
        taken = cond_eval(code, f);
    end

endmodule

// File: rtl/exec_unit.sv
module exec_unit
    import exec_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    fn_alu,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          set_flags,
    input  logic [3:0]    cond_fn,
    output logic [DW-1:0] result,
    output logic [2:0]    flags_q,
    output logic          cond_true
);
    flags_t next_f;
    flags_t held_f;

    exec_alu #(.DW(DW)) u_alu (
        .fn (fn_alu),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (result),
        .nf (next_f)
    );

    exec_ccreg u_ccreg (
        .clk  (clk),
        .rst  (rst),
        .load (set_flags),
        .d    (next_f),
        .q    (held_f)
    );

    exec_cond u_cond (
        .code  (cond_fn),
        .f     (held_f),
        .taken (cond_true)
    );

    assign flags_q = held_f;

endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    fn_alu,
    input logic          set_flags,
    input logic [3:0]    cond_fn,
    input logic [DW-1:0] result,
    input logic [2:0]    flags_q,
    input logic          cond_true
);
    // R6
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> flags_q == 3'b000);

    // R5
    hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable(flags_q));

    // R4
    load_zero_neg_chk: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flags_q[2] == ($past(result) == '0)) && (flags_q[1] == $past(result[DW-1])));

    // R4
    logic_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (set_flags && (fn_alu == 4'd2 || fn_alu == 4'd3)) |=> !flags_q[0]);

    // R7
    always_true_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_fn == 4'd0) |-> cond_true);

    // R7
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_fn > 4'd6) |-> !cond_true);

    // R7
    equal_tracks_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_fn == 4'd3) |-> (cond_true == flags_q[2]));

endmodule

bind exec_unit exec_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fn_alu    (fn_alu),
    .set_flags (set_flags),
    .cond_fn   (cond_fn),
    .result    (result),
    .flags_q   (flags_q),
    .cond_true (cond_true)
);

// File: tb/exec_unit_test.sv
`timescale 1ns/1ps
module exec_unit_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    fn_alu = 4'd0;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic          set_flags = 1'b0;
    logic [3:0]    cond_fn = 4'd0;
    logic [DW-1:0] result;
    logic [2:0]    flags_q;
    logic          cond_true;

    always #2.5 clk = ~clk;

    exec_unit #(.DW(DW)) uut (
        .clk(clk), .rst(rst), .fn_alu(fn_alu), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .set_flags(set_flags), .cond_fn(cond_fn), .result(result),
        .flags_q(flags_q), .cond_true(cond_true)
    );

    typedef struct {
        logic [DW-1:0] res;
        logic [2:0]    flg;
        logic          cnd;
        string         tag;
    } item_t;

    item_t sb[$];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [2:0] m_flags = 3'b000;
    logic       pend_set = 1'b0;
    logic [2:0] pend_flags = 3'b000;

    function automatic logic [DW-1:0] m_res(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            4'd0: return b + a;
            4'd1: return b - a;
            4'd2: return a & b;
            4'd3: return a ^ b;
            default: return '0;
        endcase
    endfunction

    function automatic logic [2:0] m_flg(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        logic v;
        r = m_res(op, a, b);
        v = 1'b0;
        if (op == 4'd0) v = ($signed(a) >= 0) == ($signed(b) >= 0) && (($signed(r) >= 0) != ($signed(b) >= 0));
        if (op == 4'd1) v = (($signed(a) >= 0) != ($signed(b) >= 0)) && (($signed(r) >= 0) != ($signed(b) >= 0));
        return {r == '0, r[DW-1], v};
    endfunction

    function automatic logic m_cnd(input logic [3:0] c, input logic [2:0] f);
        logic z, n, v;
        {z, n, v} = f;
        case (c)
            4'd0: return 1'b1;
            4'd1: return (n != v) || z;
            4'd2: return n != v;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return n == v;
            4'd6: return (n == v) && !z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic step(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic ld, input logic [3:0] c, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        if (pend_set) m_flags = pend_flags;
        fn_alu = op; opnd_a = a; opnd_b = b; set_flags = ld; cond_fn = c;
        it.res = m_res(op, a, b);
        it.flg = m_flags;
        it.cnd = m_cnd(c, m_flags);
        it.tag = tag;
        sb.push_back(it);
        pend_set = ld;
        pend_flags = m_flg(op, a, b);
    endtask

    task automatic pulse_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        set_flags = 1'b1;
        fn_alu = 4'd1; opnd_a = 32'd1; opnd_b = 32'd0;
        pend_set = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        set_flags = 1'b0;
        m_flags = 3'b000;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t e;
                e = sb.pop_front();
                checks++;
                if (result !== e.res || flags_q !== e.flg || cond_true !== e.cnd) begin
                    errors++;
                    $display("FAIL %s: got res=%h flags=%b cond=%b, expected res=%h flags=%b cond=%b",
                             e.tag, result, flags_q, cond_true, e.res, e.flg, e.cnd);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset held with load requested: must stay cleared (R6)
        rst = 1'b1; set_flags = 1'b1; fn_alu = 4'd1; opnd_a = 32'd1; opnd_b = 32'd0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0; set_flags = 1'b0;
        step(4'd0, 32'd0, 32'd0, 1'b0, 4'd4, "R6 reset state");
        // R9 example and one-cycle lag (R8)
        step(4'd0, 32'h100, 32'h200, 1'b1, 4'd3, "R9 add 0x100+0x200");
        step(4'd0, 32'h100, 32'h200, 1'b0, 4'd3, "R9 equal false");
        step(4'd1, 32'd5, 32'd5, 1'b1, 4'd3, "R8 zero not yet visible");
        step(4'd2, 32'hF0F0, 32'h0FF0, 1'b0, 4'd3, "R8 equal now true, R3 and");
        step(4'd3, 32'hF0F0, 32'h0FF0, 1'b0, 4'd4, "R3 xor, R5 hold");
        // R2 subtract order
        step(4'd1, 32'd3, 32'd10, 1'b1, 4'd1, "R2 b-a");
        step(4'd1, 32'd10, 32'd3, 1'b1, 4'd6, "R2 reversed, R7 gt");
        step(4'd0, 32'h7FFFFFFF, 32'd1, 1'b1, 4'd2, "R4 add overflow, R7 lt");
        step(4'd0, 32'h80000000, 32'h80000000, 1'b1, 4'd5, "R1 wrap to zero, R7 ge");
        step(4'd1, 32'd1, 32'h80000000, 1'b1, 4'd1, "R4 sub overflow, R7 le");
        step(4'd3, 32'hFFFFFFFF, 32'h0, 1'b1, 4'd2, "R4 overflow flags visible");
        step(4'd7, 32'h1234, 32'h5678, 1'b1, 4'd2, "R3 unused op zero, R4 xor clears ovf");
        step(4'd9, 32'h1, 32'h1, 1'b0, 4'd3, "R3 unused op, R7 eq");
        // sweep all predicate codes on stored flag 3'b100
        for (int c = 0; c < 16; c++) begin
            step(4'd12, 32'd1, 32'd2, 1'b0, c[3:0], "R7 predicate sweep");
        end
        step(4'd1, 32'd1, 32'd0, 1'b1, 4'd0, "R1 R7 always");
        for (int c = 0; c < 8; c++) begin
            step(4'd0, 32'd7, 32'd9, 1'b0, c[3:0], "R7 sweep negative flags, R5 hold");
        end
        // mid-run reset (R6)
        pulse_reset();
        step(4'd0, 32'd1, 32'd1, 1'b0, 4'd3, "R6 cleared after reset");
        step(4'd0, 32'd1, 32'd1, 1'b0, 4'd5, "R6 R5 still clear");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule